// File: doc/BRIEF.md
# CAN Receive Message Object Manager

This block owns the receive-side message objects of one CAN channel. A frame decoder upstream hands over frames that are already decoded and already matched to an object. Each frame carries the object index, the identifier, the extended and remote flags, the length code and up to eight data bytes. For an armed object the manager writes the frame into a RAM region as four consecutive 32-bit words and updates that object's flags. A frame for an object that is not armed is consumed and discarded.

Every object has an enable (armed) bit, a message-ready flag and an overwrite flag. One channel-wide overrun-mode bit selects what happens after a reception. With the bit clear, the object disarms itself. With the bit set, it stays armed, and a frame that lands while the earlier message is still unread is recorded in the overwrite flag. Software uses a small register port to set the storage base address, arm and disarm objects, and clear flags.

Both data paths use valid/ready handshakes. Frames enter on `fr_valid`/`fr_ready`. The decoder must hold a frame until `fr_ready` is high, and the manager accepts one frame at a time. RAM words leave on `ram_wvalid`/`ram_wready`. While `ram_wready` is low, the manager holds the word and its address unchanged.

Top module: `rxobj_manager`

## Requirements
- R1: After reset every object is disarmed, every ready and overwrite flag is clear, overrun mode is off, the base address is 0, `fr_ready` is 1 and `ram_wvalid` is 0.
- R2: A frame is taken in a cycle where `fr_valid` and `fr_ready` are both high. For an armed object, `fr_ready` goes low from the next cycle until the fourth RAM word has been accepted, and is high again in the cycle after that. For an unarmed object, `fr_ready` stays high.
- R3: For an armed object, exactly four RAM writes go out, at word addresses base+index*4+0, +1, +2 and +3 (modulo 2^AW), in ascending order:
  - Word 0 is {ext at bit 31, rtr at bit 30, 0 at bit 29, identifier at bits 28:0}.
  - Word 1 holds the length code in bits 3:0, with the other bits zero.
  - Word 2 is `fr_data[31:0]` and word 3 is `fr_data[63:32]`, where data byte k enters on `fr_data[8k+7:8k]`.
- R4: While `ram_wvalid` is high and `ram_wready` is low, `ram_wvalid`, `ram_waddr` and `ram_wdata` hold their values into the next cycle.
- R5: A frame for an unarmed object issues no RAM write and changes no enable, ready or overwrite bit.
- R6: With overrun mode off, an armed object is disarmed by the frame it takes.
- R7: With overrun mode on, an armed object stays armed after the frame it takes.
- R8: Taking a frame sets the object's ready flag. Writing 1 to the ready flag's bit clears it.
- R9: If an object takes a frame while its ready flag is already set, its overwrite flag is set. Writing 1 to the overwrite flag's bit clears it.
- R10: Register map, selected by `reg_addr` and read combinationally on `reg_rdata`. Bit i of the object registers belongs to object i. Unused bits and offsets read zero.

  | Offset | Register | Write | Read |
  |---|---|---|---|
  | 0 | Configuration | bit 0 is overrun mode | bit 0 |
  | 1 | Base address | word address in bits AW-1:0 | base address |
  | 2 | Arm | 1s arm objects | enable bits |
  | 3 | Disarm | 1s disarm objects | zero |
  | 4 | Ready | 1s clear ready flags | ready flags |
  | 5 | Overwrite | 1s clear overwrite flags | overwrite flags |

- R11: The base address is taken when a frame is accepted. A new base value moves the RAM addresses of every frame accepted after the write, and only the base register sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | Decoded frame present |
| fr_ready | output | 1 | Manager can take a frame |
| fr_obj | input | IDXW | Target object index |
| fr_id | input | 29 | Identifier (11-bit identifiers right-aligned) |
| fr_ext | input | 1 | Extended identifier flag |
| fr_rtr | input | 1 | Remote frame flag |
| fr_len | input | 4 | Length code |
| fr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| ram_wvalid | output | 1 | RAM word write pending |
| ram_wready | input | 1 | RAM takes the word this cycle |
| ram_waddr | output | AW | RAM word address |
| ram_wdata | output | 32 | RAM word data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The assertions on automatic disarm and on keeping an object armed assume that no software arm or disarm write lands in the same cycle as a frame acceptance. They exclude that cycle explicitly, because in that case the software write takes priority. The bench keeps register writes and frame transfers in separate phases, and it only starts a register write once `fr_ready` is back high. It drives `ram_wready` at random, and also holds it low for stretches, so the back-pressure hold property is exercised while each four-word burst is running.

// File: rtl/rxobj_pkg.sv
package rxobj_pkg;

  localparam int ID_W          = 29;
  localparam int WORD_W        = 32;
  localparam int WORDS_PER_OBJ = 4;
  localparam int REG_AW        = 3;

  localparam logic [REG_AW-1:0] RA_CFG    = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE   = 3'd1;
  localparam logic [REG_AW-1:0] RA_ARM    = 3'd2;
  localparam logic [REG_AW-1:0] RA_DISARM = 3'd3;
  localparam logic [REG_AW-1:0] RA_READY  = 3'd4;
  localparam logic [REG_AW-1:0] RA_OVW    = 3'd5;

  typedef struct packed {
    logic            ext;
    logic            rtr;
    logic [ID_W-1:0] id;
    logic [3:0]      len;
    logic [63:0]     data;
  } frame_t;

  // Builds one of the four stored words of a frame
  function automatic logic [WORD_W-1:0] pack_word(input frame_t f, input logic [1:0] w);
    logic [WORD_W-1:0] r;
    case (w)
      2'd0:    r = {f.ext, f.rtr, 1'b0, f.id};
      2'd1:    r = {28'd0, f.len};
      2'd2:    r = f.data[31:0];
      default: r = f.data[63:32];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxobj_slot_addr.sv
module rxobj_slot_addr #(
  parameter int AW   = 16,
  parameter int IDXW = 3
) (
  input  logic [AW-1:0]   base,
  input  logic [IDXW-1:0] idx,
  output logic [AW-1:0]   slot
);
  localparam int STRIDE_SH = $clog2(rxobj_pkg::WORDS_PER_OBJ);

  assign slot = base + (AW'(idx) << STRIDE_SH);
endmodule

// File: rtl/rxobj_regs.sv
module rxobj_regs
  import rxobj_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int IDXW    = 3,
  parameter int AW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              hw_take,
  input  logic [IDXW-1:0]   hw_idx,
  output logic              hw_hit,
  output logic              ovr_mode,
  output logic [AW-1:0]     base
);

  logic [NUM_OBJ-1:0] en_q, en_d, rdy_q, rdy_d, ovw_q, ovw_d, sel;
  logic               ovr_q;
  logic [AW-1:0]      base_q;
  logic               wr_arm, wr_dis, wr_rdy, wr_ovw;
  logic               unused_wdata;

  assign wr_arm = reg_we && (reg_addr == RA_ARM);
  assign wr_dis = reg_we && (reg_addr == RA_DISARM);
  assign wr_rdy = reg_we && (reg_addr == RA_READY);
  assign wr_ovw = reg_we && (reg_addr == RA_OVW);
  assign unused_wdata = ^reg_wdata;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic take_g;
    assign sel[g]  = (hw_idx == IDXW'(g));
    assign take_g  = hw_take && sel[g] && en_q[g];
    // Software arm/disarm wins over the automatic disarm
    assign en_d[g] = (wr_arm && reg_wdata[g]) ? 1'b1 :
                     (wr_dis && reg_wdata[g]) ? 1'b0 :
                     (take_g && !ovr_q)       ? 1'b0 : en_q[g];
    // A reception wins over a clear in the same cycle
    assign rdy_d[g] = take_g ? 1'b1 : (wr_rdy && reg_wdata[g]) ? 1'b0 : rdy_q[g];
    assign ovw_d[g] = (take_g && rdy_q[g]) ? 1'b1 :
                      (wr_ovw && reg_wdata[g]) ? 1'b0 : ovw_q[g];
  end

  assign hw_hit   = |(en_q & sel);
  assign ovr_mode = ovr_q;
  assign base     = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      rdy_q  <= '0;
      ovw_q  <= '0;
      ovr_q  <= 1'b0;
      base_q <= '0;
    end else begin
      en_q  <= en_d;
      rdy_q <= rdy_d;
      ovw_q <= ovw_d;
      if (reg_we && reg_addr == RA_CFG)  ovr_q  <= reg_wdata[0];
      if (reg_we && reg_addr == RA_BASE) base_q <= reg_wdata[AW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CFG:   reg_rdata = {{(WORD_W-1){1'b0}}, ovr_q};
      RA_BASE:  reg_rdata = WORD_W'(base_q);
      RA_ARM:   reg_rdata = WORD_W'(en_q);
      RA_READY: reg_rdata = WORD_W'(rdy_q);
      RA_OVW:   reg_rdata = WORD_W'(ovw_q);
      default:  reg_rdata = '0;
    endcase
  end

  AST_NORMAL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && hw_hit && !ovr_q && !wr_arm) |=> !en_q[$past(hw_idx)]); // R6
  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && hw_hit && ovr_q && !wr_dis) |=> en_q[$past(hw_idx)]); // R7
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && hw_hit) |=> rdy_q[$past(hw_idx)]); // R8
  AST_OVW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && hw_hit && |(rdy_q & sel)) |=> ovw_q[$past(hw_idx)]); // R9
  AST_DROP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_take && !hw_hit && !reg_we) |=> ($stable(rdy_q) && $stable(ovw_q) && $stable(en_q))); // R5

endmodule

// File: rtl/rxobj_writer.sv
module rxobj_writer
  import rxobj_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  frame_t            in_frame,
  input  logic [AW-1:0]     in_slot,
  input  logic              in_hit,
  output logic              take,
  output logic              ram_wvalid,
  input  logic              ram_wready,
  output logic [AW-1:0]     ram_waddr,
  output logic [WORD_W-1:0] ram_wdata
);
  localparam int WSEL_W = $clog2(WORDS_PER_OBJ);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS_PER_OBJ - 1);

  logic              busy_q;
  logic [WSEL_W-1:0] word_q;
  frame_t            frame_q;
  logic [AW-1:0]     slot_q;

  assign fr_ready   = !busy_q;
  assign take       = fr_valid && fr_ready;
  assign ram_wvalid = busy_q;
  assign ram_waddr  = slot_q + AW'(word_q);
  assign ram_wdata  = pack_word(frame_q, word_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      word_q  <= '0;
      frame_q <= '0;
      slot_q  <= '0;
    end else if (!busy_q) begin
      if (take && in_hit) begin
        busy_q  <= 1'b1;
        word_q  <= '0;
        frame_q <= in_frame;
        slot_q  <= in_slot;
      end
    end else if (ram_wready) begin
      if (word_q == LAST_WORD) busy_q <= 1'b0;
      else                     word_q <= word_q + 1'b1;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wvalid && !ram_wready) |=> (ram_wvalid && $stable(ram_waddr) && $stable(ram_wdata))); // R4
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wvalid && ram_wready && word_q != LAST_WORD) |=> (ram_waddr == $past(ram_waddr) + AW'(1))); // R3
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wvalid && ram_wready && word_q == LAST_WORD) |=> fr_ready); // R2
  AST_HIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_hit) |=> !fr_ready); // R2

endmodule

// File: rtl/rxobj_manager.sv
module rxobj_manager
  import rxobj_pkg::*;
#(
  parameter int NUM_OBJ = 8,
  parameter int AW      = 16,
  parameter int IDXW    = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [IDXW-1:0]   fr_obj,
  input  logic [ID_W-1:0]   fr_id,
  input  logic              fr_ext,
  input  logic              fr_rtr,
  input  logic [3:0]        fr_len,
  input  logic [63:0]       fr_data,
  output logic              ram_wvalid,
  input  logic              ram_wready,
  output logic [AW-1:0]     ram_waddr,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata
);

  frame_t        in_frame;
  logic          take, hit, ovr_mode;
  logic [AW-1:0] base, slot;

  assign in_frame = '{ext: fr_ext, rtr: fr_rtr, id: fr_id, len: fr_len, data: fr_data};

  rxobj_regs #(.NUM_OBJ(NUM_OBJ), .IDXW(IDXW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_take(take), .hw_idx(fr_obj), .hw_hit(hit), .ovr_mode(ovr_mode), .base(base)
  );

  rxobj_slot_addr #(.AW(AW), .IDXW(IDXW)) u_slot (
    .base(base), .idx(fr_obj), .slot(slot)
  );

  rxobj_writer #(.AW(AW)) u_writer (
    .clk(clk), .rst_n(rst_n),
    .fr_valid(fr_valid), .fr_ready(fr_ready),
    .in_frame(in_frame), .in_slot(slot), .in_hit(hit), .take(take),
    .ram_wvalid(ram_wvalid), .ram_wready(ram_wready),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> !ram_wvalid); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (fr_ready && !ram_wvalid)); // R1
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit) |=> (ram_waddr == $past(base) + (AW'($past(fr_obj)) << 2))); // R11
  AST_OVR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ovr_mode)); // R10

endmodule

// File: tb/test_rxobj_manager.sv
module test_rxobj_manager;
  localparam int NOBJ = 8;
  localparam int AW   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_valid = 1'b0;
  logic        fr_ready;
  logic [2:0]  fr_obj = '0;
  logic [28:0] fr_id = '0;
  logic        fr_ext = 1'b0, fr_rtr = 1'b0;
  logic [3:0]  fr_len = '0;
  logic [63:0] fr_data = '0;
  logic        ram_wvalid, ram_wready = 1'b0;
  logic [15:0] ram_waddr;
  logic [31:0] ram_wdata;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int tests = 0, fails = 0;
  int stall_cycles = 0;
  logic [47:0] expq[$];
  logic [7:0]  m_en = '0, m_rdy = '0, m_ovw = '0;
  logic        m_ovr = 1'b0;
  logic [15:0] m_base = '0;

  always #10 clk = ~clk;

  rxobj_manager #(.NUM_OBJ(NOBJ), .AW(AW)) i_rxobj_manager (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_obj(fr_obj), .fr_id(fr_id), .fr_ext(fr_ext), .fr_rtr(fr_rtr),
    .fr_len(fr_len), .fr_data(fr_data),
    .ram_wvalid(ram_wvalid), .ram_wready(ram_wready),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w, input logic [28:0] id, input logic ext,
                                           input logic rtr, input logic [3:0] len, input logic [63:0] d);
    case (w)
      0: return {ext, rtr, 1'b0, id};
      1: return {28'd0, len};
      2: return d[31:0];
      default: return d[63:32];
    endcase
  endfunction

  // RAM side: random ready, records and checks every accepted word
  initial begin
    logic        prev_stall = 1'b0;
    logic [15:0] prev_a = '0;
    logic [31:0] prev_d = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) ram_wready = 1'b0;
      else if (stall_cycles > 0) begin ram_wready = 1'b0; stall_cycles--; end
      else ram_wready = ($urandom % 4) != 0;
      #2;
      if (prev_stall)
        chk(ram_wvalid && ram_waddr == prev_a && ram_wdata == prev_d, "R4 held word",
            {ram_waddr, ram_wdata}, {prev_a, prev_d});
      if (ram_wvalid && fr_ready) chk(1'b0, "R2 ready while busy", 1, 0);
      prev_stall = ram_wvalid && !ram_wready;
      prev_a = ram_waddr;
      prev_d = ram_wdata;
      if (ram_wvalid && ram_wready) begin
        if (expq.size() == 0) chk(1'b0, "R5 unexpected RAM write", {ram_waddr, ram_wdata}, 0);
        else begin
          logic [47:0] e;
          e = expq.pop_front();
          chk({ram_waddr, ram_wdata} == e, "R3 RAM word", {ram_waddr, ram_wdata}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    case (a)
      3'd0: m_ovr = d[0];
      3'd1: m_base = d[15:0];
      3'd2: m_en = m_en | d[7:0];
      3'd3: m_en = m_en & ~d[7:0];
      3'd4: m_rdy = m_rdy & ~d[7:0];
      3'd5: m_ovw = m_ovw & ~d[7:0];
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #3 d = reg_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    reg_read(3'd0, d); chk(d == {31'd0, m_ovr}, {tag, " R10 cfg"}, d, {31'd0, m_ovr});
    reg_read(3'd1, d); chk(d == {16'd0, m_base}, {tag, " R11 base"}, d, {16'd0, m_base});
    reg_read(3'd2, d); chk(d == {24'd0, m_en}, {tag, " R6/R7 enable"}, d, {24'd0, m_en});
    reg_read(3'd3, d); chk(d == 32'd0, {tag, " R10 disarm reads zero"}, d, 0);
    reg_read(3'd4, d); chk(d == {24'd0, m_rdy}, {tag, " R8 ready"}, d, {24'd0, m_rdy});
    reg_read(3'd5, d); chk(d == {24'd0, m_ovw}, {tag, " R9 overwrite"}, d, {24'd0, m_ovw});
  endtask

  task automatic send(input logic [2:0] obj, input logic [28:0] id, input logic ext,
                      input logic rtr, input logic [3:0] len, input logic [63:0] d);
    bit hit;
    int guard;
    @(negedge clk);
    fr_valid = 1'b1; fr_obj = obj; fr_id = id; fr_ext = ext; fr_rtr = rtr;
    fr_len = len; fr_data = d;
    #2;
    while (!fr_ready) begin @(negedge clk); #2; end
    hit = m_en[obj];
    if (hit) begin
      for (int w = 0; w < 4; w++)
        expq.push_back({m_base + 16'(obj) * 16'd4 + 16'(w), exp_word(w, id, ext, rtr, len, d)});
      m_ovw[obj] = m_ovw[obj] | m_rdy[obj];
      m_rdy[obj] = 1'b1;
      if (!m_ovr) m_en[obj] = 1'b0;
    end
    @(posedge clk); #1;
    fr_valid = 1'b0;
    @(negedge clk); #2;
    chk(fr_ready == !hit, "R2 ready after accept", fr_ready, !hit);
    guard = 0;
    while (!fr_ready && guard < 1000) begin @(negedge clk); #2; guard++; end
    @(negedge clk); #2;
    chk(expq.size() == 0, "R3 four words written", expq.size(), 0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    #2;
    chk(fr_ready == 1'b1 && ram_wvalid == 1'b0, "R1 reset handshake", {fr_ready, ram_wvalid}, 2'b10);
    rst_n = 1'b1;
    check_regs("R1 reset");

    reg_write(3'd1, 32'h0000_0100);
    reg_write(3'd2, 32'h0000_0008);
    check_regs("R10 setup");

    // normal mode reception: disarm, ready set
    send(3'd3, 29'h1ABC_DEF0, 1'b1, 1'b0, 4'd8, 64'h8877_6655_4433_2211);
    check_regs("R6 auto-disarm");

    // frame to a disarmed object is dropped
    send(3'd3, 29'h123, 1'b0, 1'b1, 4'd2, 64'hFFFF);
    check_regs("R5 dropped");

    // re-arm while still unread: overwrite
    reg_write(3'd2, 32'h0000_0008);
    stall_cycles = 6;
    send(3'd3, 29'h7FF, 1'b0, 1'b0, 4'd1, 64'hAA);
    check_regs("R9 overwrite set");
    reg_write(3'd5, 32'h0000_0008);
    reg_write(3'd4, 32'h0000_0008);
    check_regs("R8/R9 cleared");

    // overrun mode keeps objects armed
    reg_write(3'd0, 32'h1);
    reg_write(3'd2, 32'h0000_00FF);
    send(3'd5, 29'h55, 1'b0, 1'b0, 4'd3, 64'h00_C0FFEE);
    send(3'd5, 29'h56, 1'b1, 1'b1, 4'd0, 64'h0);
    check_regs("R7 overrun");

    // base near top of address space: wrap
    reg_write(3'd1, 32'h0000_FFFE);
    send(3'd7, 29'h1FFF_FFFF, 1'b1, 1'b1, 4'd15, 64'hDEAD_BEEF_0BAD_F00D);
    check_regs("R11 new base");

    // constrained random phase
    for (int i = 0; i < 160; i++) begin
      int op;
      op = $urandom % 10;
      if (op < 6) begin
        send(3'($urandom), 29'($urandom), 1'($urandom), 1'($urandom),
             4'($urandom), {$urandom, $urandom});
      end else if (op == 6) reg_write(3'd2, 32'($urandom % 256));
      else if (op == 7) reg_write(3'd3, 32'($urandom % 256));
      else if (op == 8) reg_write(3'(4 + $urandom % 2), 32'($urandom % 256));
      else reg_write(3'($urandom % 2), $urandom);
      if (i % 8 == 0) stall_cycles = 3;
      check_regs("random");
    end

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R3 no pending words", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule